// File: doc/BRIEF.md
# Asynchronous DRAM Access Sequencer

The sequencer turns one host request into a complete strobe sequence for an asynchronous page-mode DRAM. It drives the row strobe, column strobe, write enable and output enable (all active low), a shared row/column address bus, and a tri-state data bus. Each accepted request runs exactly one access of one of three kinds:

- a read;
- an early write, where write enable is already low when the column strobe falls, so the memory never drives the bus;
- a read-modify-write, which reads the old word and then writes the new one within the same row and column strobe pulses.

Every analog limit is held as a nanosecond parameter. Each limit is converted to a clock count by rounding up at the configured clock period. A grade parameter picks the fast or the slow set of limits. The host sees a ready/valid handshake: `reqReady` is high only when a new access may start. `rspValid` pulses once per access and, for reads and read-modify-writes, carries the word read from the memory.

Top module: `adram_seq`

## Requirements
- R1: After reset all four strobes are high (inactive), the sequencer does not drive the data bus, `rspValid` is low and `reqReady` is high.
- R2: In a read or early write the row strobe stays low at least 50 ns. The column strobe stays low at least 8 ns, is still low 35 ns after the row strobe fell, and the row strobe is still low 13 ns after the column strobe fell. The column strobe is low only while the row strobe is low.
- R3: The row half of the address (request bits [20:10]) is on the bus one cycle before and during the row strobe fall. The column half (bits [9:0], zero-extended) appears exactly one cycle before the column strobe falls. It stays until both strobes rise, at least 25 ns before the row strobe rises and 13 ns before the column strobe rises.
- R4: In a read (kind code 0) write enable stays high and output enable is low while the column strobe is low. The bus is sampled in the last cycle before the column strobe rises. The word is returned on `rspData` with a one-cycle `rspValid` pulse in the cycle the row strobe rises.
- R5: In an early write (kind code 1) write enable falls no later than the column strobe. It stays low at least 8 ns after the column strobe falls. The write word is driven for every cycle write enable is low, and output enable stays high for the whole access.
- R6: In a read-modify-write (kind code 2) the row strobe is low at least 75 ns and the column strobe at least 38 ns. The column strobe is still low 70 ns after the row strobe fell, and the row strobe is still low 38 ns after the column strobe fell.
- R7: In a read-modify-write, write enable falls no earlier than 28 ns after the column strobe falls, 65 ns after the row strobe falls, and 40 ns after the column address appears. Output enable stays low at least 13 ns past that fall. The write word is driven only with output enable high, and is on the bus in the last cycle write enable is low.
- R8: Write enable stays low at least 8 ns, and both strobes stay low at least 8 ns after write enable falls.
- R9: A read-modify-write returns the word stored before the access, and afterwards the location holds the new word.
- R10: Row-strobe falls of consecutive accesses are at least 84 ns apart after a read or early write and 109 ns apart after a read-modify-write. With a request held, the next fall comes within one cycle of that minimum. While busy `reqReady` is low and requests have no effect on the strobes or the memory.
- R11: Kind code 3 performs a read.
- R12: Limits round up to whole cycles at the clock period. At the default 4 ns period and fast grade, a read holds the row strobe low exactly 13 cycles, and the column strobe rises exactly 9 cycles after the row strobe fell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Sequencer idle; request taken when both high |
| reqKind | input | 2 | 0 read, 1 early write, 2 read-modify-write, 3 read |
| reqAddr | input | ROW_W+COL_W | Row in upper bits, column in lower bits |
| reqWdata | input | DQ_W | Word to write |
| rspValid | output | 1 | One-cycle pulse at the end of each access |
| rspData | output | DQ_W | Word read from the memory |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramOeN | output | 1 | Output enable, active low |
| dramAddr | output | max(ROW_W,COL_W) | Multiplexed address |
| dramDq | inout | DQ_W | Bidirectional data bus |

## Verification
A request is taken on the edge where `reqValid` and `reqReady` are both high. The internal step count starts on that edge, and every memory-side pin follows its step one cycle later through the output registers. The row strobe therefore falls on the second edge after the request is first seen, and `rspValid` rises on the same edge as the row strobe. The bench samples all pins at falling clock edges and records the sample index of every strobe edge. It checks timing limits as differences between those indices, so a uniform latency shift cannot hide a short pulse. Data is checked against a bench memory model that answers reads and commits writes when write enable rises.

// File: rtl/adseq_pkg.sv
package adseq_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_EWR   = 2'd1,
    ACC_RMW   = 2'd2,
    ACC_READ2 = 2'd3
  } acc_e;

  // control-to-datapath strobe bundle, one step ahead of the pins
  typedef struct packed {
    logic rasLow;
    logic casLow;
    logic weLow;
    logic oeLow;
    logic selCol;
    logic dqDrive;
    logic capture;
    logic done;
  } strobe_t;

  function automatic int nsToCyc(input int ns, input int periodPs);
    return (ns * 1000 + periodPs - 1) / periodPs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adseq_ctrl.sv
module adseq_ctrl
  import adseq_pkg::*;
#(
  parameter int CLK_PS     = 4000,
  parameter int SLOW_GRADE = 0,
  parameter int RCD_NS     = 15,
  parameter int RP_NS      = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  output logic       reqReady,
  output logic       load,
  output strobe_t    strobes
);

  localparam bit S = (SLOW_GRADE != 0);

  // limits in cycles
  localparam int C_RC    = nsToCyc(S ? 104 : 84, CLK_PS);
  localparam int C_RAS   = nsToCyc(S ? 60 : 50, CLK_PS);
  localparam int C_CAS   = nsToCyc(S ? 10 : 8, CLK_PS);
  localparam int C_CSH   = nsToCyc(S ? 40 : 35, CLK_PS);
  localparam int C_RSH   = nsToCyc(S ? 15 : 13, CLK_PS);
  localparam int C_RAL   = nsToCyc(S ? 30 : 25, CLK_PS);
  localparam int C_CAL   = nsToCyc(S ? 18 : 13, CLK_PS);
  localparam int C_WCH   = nsToCyc(S ? 10 : 8, CLK_PS);
  localparam int C_CWL   = nsToCyc(S ? 10 : 8, CLK_PS);
  localparam int C_RWL   = nsToCyc(S ? 10 : 8, CLK_PS);
  localparam int C_WP    = nsToCyc(S ? 10 : 8, CLK_PS);
  localparam int C_DH    = nsToCyc(S ? 10 : 8, CLK_PS);
  localparam int C_RWC   = nsToCyc(S ? 133 : 109, CLK_PS);
  localparam int C_RAS_M = nsToCyc(S ? 89 : 75, CLK_PS);
  localparam int C_CAS_M = nsToCyc(S ? 44 : 38, CLK_PS);
  localparam int C_CSH_M = nsToCyc(S ? 82 : 70, CLK_PS);
  localparam int C_RSH_M = nsToCyc(S ? 44 : 38, CLK_PS);
  localparam int C_CWD   = nsToCyc(S ? 32 : 28, CLK_PS);
  localparam int C_RWD   = nsToCyc(S ? 77 : 65, CLK_PS);
  localparam int C_AWD   = nsToCyc(S ? 47 : 40, CLK_PS);
  localparam int C_OEH   = nsToCyc(S ? 15 : 13, CLK_PS);
  localparam int C_RCD   = nsToCyc(RCD_NS, CLK_PS);
  localparam int C_RP    = nsToCyc(RP_NS, CLK_PS);

  // step at which each event happens, counted from the first row-strobe-low step
  localparam int CAS_AT = maxOf(C_RCD, 1);
  localparam int COL_AT = CAS_AT - 1;

  localparam int R_CAS_UP = maxOf(maxOf(CAS_AT + C_CAS, C_CSH), COL_AT + C_CAL);
  localparam int R_RAS_UP = maxOf(maxOf(C_RAS, CAS_AT + C_RSH),
                                  maxOf(COL_AT + C_RAL, R_CAS_UP));
  localparam int R_END    = maxOf(C_RC, R_RAS_UP + C_RP);
  localparam int R_CAP    = R_CAS_UP - 1;

  localparam int W_WE_DN  = COL_AT;
  localparam int W_WE_UP  = maxOf(CAS_AT + C_WCH, W_WE_DN + C_WP);
  localparam int W_CAS_UP = maxOf(R_CAS_UP, W_WE_DN + C_CWL);
  localparam int W_RAS_UP = maxOf(R_RAS_UP, maxOf(W_WE_DN + C_RWL, W_CAS_UP));
  localparam int W_END    = maxOf(C_RC, W_RAS_UP + C_RP);

  localparam int M_WE_DN  = maxOf(maxOf(CAS_AT + C_CWD, C_RWD), COL_AT + C_AWD);
  localparam int M_OE_UP  = M_WE_DN + C_OEH;
  localparam int M_WE_UP  = maxOf(M_OE_UP + C_DH, M_WE_DN + C_WP);
  localparam int M_CAS_UP = maxOf(maxOf(CAS_AT + C_CAS_M, C_CSH_M),
                                  maxOf(maxOf(M_WE_DN + C_CWL, M_WE_UP), COL_AT + C_CAL));
  localparam int M_RAS_UP = maxOf(maxOf(C_RAS_M, CAS_AT + C_RSH_M),
                                  maxOf(maxOf(M_WE_DN + C_RWL, M_CAS_UP), COL_AT + C_RAL));
  localparam int M_END    = maxOf(C_RWC, M_RAS_UP + C_RP);
  localparam int M_CAP    = M_WE_DN - 1;

  localparam int END_MAX = maxOf(R_END, maxOf(W_END, M_END));
  localparam int CNT_W   = $clog2(END_MAX + 1);

  typedef enum logic {S_IDLE, S_RUN} state_e;

  state_e           state;
  logic [CNT_W-1:0] stepCnt;
  acc_e             kindQ;

  int step;
  int casUp, rasUp, endAt;
  logic lastStep;

  assign reqReady = (state == S_IDLE);
  assign load     = reqReady && reqValid;
  assign step     = int'(stepCnt);

  always_comb begin
    case (kindQ)
      ACC_EWR: begin casUp = W_CAS_UP; rasUp = W_RAS_UP; endAt = W_END; end
      ACC_RMW: begin casUp = M_CAS_UP; rasUp = M_RAS_UP; endAt = M_END; end
      default: begin casUp = R_CAS_UP; rasUp = R_RAS_UP; endAt = R_END; end
    endcase
  end

  assign lastStep = (state == S_RUN) && (step == endAt - 1);

  always_comb begin
    strobes = '0;
    if (state == S_RUN) begin
      strobes.rasLow = (step < rasUp);
      strobes.casLow = (step >= CAS_AT) && (step < casUp);
      strobes.selCol = (step >= COL_AT);
      strobes.done   = (step == rasUp);
      case (kindQ)
        ACC_EWR: begin
          strobes.weLow   = (step >= W_WE_DN) && (step < W_WE_UP);
          strobes.dqDrive = (step >= W_WE_DN) && (step < W_WE_UP);
        end
        ACC_RMW: begin
          strobes.weLow   = (step >= M_WE_DN) && (step < M_WE_UP);
          strobes.oeLow   = (step >= CAS_AT) && (step < M_OE_UP);
          strobes.dqDrive = (step >= M_OE_UP) && (step < M_WE_UP);
          strobes.capture = (step == M_CAP);
        end
        default: begin
          strobes.oeLow   = (step >= CAS_AT) && (step < R_CAS_UP);
          strobes.capture = (step == R_CAP);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      kindQ   <= ACC_READ;
    end else if (load) begin
      state   <= S_RUN;
      stepCnt <= '0;
      kindQ   <= acc_e'(reqKind);
    end else if (lastStep) begin
      state   <= S_IDLE;
      stepCnt <= '0;
    end else if (state == S_RUN) begin
      stepCnt <= stepCnt + 1'b1;
    end
  end

  // R10: the access kind cannot change while an access is under way
  p_kind_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN) |=> $stable(kindQ));

endmodule

// File: rtl/adseq_datapath.sv
module adseq_datapath
  import adseq_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int COL_W = 10,
  parameter int DQ_W  = 16,
  localparam int AW   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   load,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic [DQ_W-1:0]        reqWdata,
  input  strobe_t                strobes,
  output logic                   rspValid,
  output logic [DQ_W-1:0]        rspData,
  output logic                   dramRasN,
  output logic                   dramCasN,
  output logic                   dramWeN,
  output logic                   dramOeN,
  output logic [AW-1:0]          dramAddr,
  inout  wire  [DQ_W-1:0]        dramDq
);

  logic [ROW_W-1:0] rowQ;
  logic [COL_W-1:0] colQ;
  logic [DQ_W-1:0]  wdataQ;
  logic             dqOeQ;
  logic             capQ;
  logic [AW-1:0]    rowPad, colPad, reqRowPad;

  always_comb begin
    rowPad    = '0;
    colPad    = '0;
    reqRowPad = '0;
    rowPad[ROW_W-1:0]    = rowQ;
    colPad[COL_W-1:0]    = colQ;
    reqRowPad[ROW_W-1:0] = reqAddr[ROW_W+COL_W-1:COL_W];
  end

  assign dramDq = dqOeQ ? wdataQ : {DQ_W{1'bz}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ     <= '0;
      colQ     <= '0;
      wdataQ   <= '0;
      dramRasN <= 1'b1;
      dramCasN <= 1'b1;
      dramWeN  <= 1'b1;
      dramOeN  <= 1'b1;
      dramAddr <= '0;
      dqOeQ    <= 1'b0;
      capQ     <= 1'b0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (load) begin
        rowQ   <= reqAddr[ROW_W+COL_W-1:COL_W];
        colQ   <= reqAddr[COL_W-1:0];
        wdataQ <= reqWdata;
      end
      dramRasN <= !strobes.rasLow;
      dramCasN <= !strobes.casLow;
      dramWeN  <= !strobes.weLow;
      dramOeN  <= !strobes.oeLow;
      dqOeQ    <= strobes.dqDrive;
      capQ     <= strobes.capture;
      rspValid <= strobes.done;
      if (load)                dramAddr <= reqRowPad;
      else if (strobes.selCol) dramAddr <= colPad;
      else                     dramAddr <= rowPad;
      if (capQ) rspData <= dramDq;
    end
  end

  // R2: column strobe only inside the row strobe
  p_cas_in_ras_r2: assert property (@(posedge clk) disable iff (!rstN)
    !dramCasN |-> !dramRasN);
  // R7: no bus drive while the memory's output is enabled
  p_bus_oe_r7: assert property (@(posedge clk) disable iff (!rstN)
    dqOeQ |-> dramOeN);
  // R3: column address settled a cycle before the column strobe falls
  p_col_setup_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramCasN) |-> $stable(dramAddr));
  // R4: one response pulse per access
  p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  // R8: write enable only falls inside a row strobe
  p_we_in_ras_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramWeN) |-> !dramRasN);

endmodule

// File: rtl/adram_seq.sv
module adram_seq
  import adseq_pkg::*;
#(
  parameter int CLK_PS     = 4000,
  parameter int SLOW_GRADE = 0,
  parameter int RCD_NS     = 15,
  parameter int RP_NS      = 20,
  parameter int ROW_W      = 11,
  parameter int COL_W      = 10,
  parameter int DQ_W       = 16,
  localparam int AW        = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic [1:0]             reqKind,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic [DQ_W-1:0]        reqWdata,
  output logic                   rspValid,
  output logic [DQ_W-1:0]        rspData,
  output logic                   dramRasN,
  output logic                   dramCasN,
  output logic                   dramWeN,
  output logic                   dramOeN,
  output logic [AW-1:0]          dramAddr,
  inout  wire  [DQ_W-1:0]        dramDq
);

  strobe_t strobes;
  logic    load;

  adseq_ctrl #(
    .CLK_PS(CLK_PS), .SLOW_GRADE(SLOW_GRADE), .RCD_NS(RCD_NS), .RP_NS(RP_NS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqReady(reqReady), .load(load), .strobes(strobes)
  );

  adseq_datapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .load(load), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .strobes(strobes), .rspValid(rspValid), .rspData(rspData),
    .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN), .dramOeN(dramOeN),
    .dramAddr(dramAddr), .dramDq(dramDq)
  );

endmodule

// File: tb/adram_seq_tb.sv
`timescale 1ns/1ps
module adram_seq_tb;

  localparam int PER_PS = 4000;

  typedef struct packed {
    logic [1:0]  kind;
    logic [10:0] row;
    logic [9:0]  col;
    logic [15:0] wd;
    logic [15:0] exp;
    logic        chk;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 11'h401, 10'h202, 16'h0000, 16'hA006, 1'b1},
    '{2'd1, 11'h401, 10'h202, 16'h1234, 16'h0000, 1'b0},
    '{2'd0, 11'h401, 10'h202, 16'h0000, 16'h1234, 1'b1},
    '{2'd2, 11'h401, 10'h202, 16'h5678, 16'h1234, 1'b1},
    '{2'd0, 11'h401, 10'h202, 16'h0000, 16'h5678, 1'b1},
    '{2'd3, 11'h002, 10'h103, 16'h0000, 16'hA00B, 1'b1},
    '{2'd2, 11'h7FB, 10'h000, 16'h9ABC, 16'hA00C, 1'b1},
    '{2'd0, 11'h7FB, 10'h000, 16'h0000, 16'h9ABC, 1'b1},
    '{2'd1, 11'h000, 10'h3F1, 16'h0F0F, 16'h0000, 1'b0},
    '{2'd0, 11'h000, 10'h3F1, 16'h0000, 16'h0F0F, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqKind = '0;
  logic [20:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        rspValid;
  logic [15:0] rspData;
  logic        rasN, casN, weN, oeN;
  logic [10:0] dAddr;
  wire  [15:0] dq;

  adram_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData),
    .dramRasN(rasN), .dramCasN(casN), .dramWeN(weN), .dramOeN(oeN),
    .dramAddr(dAddr), .dramDq(dq)
  );

  always #2 clk = ~clk;

  int nChk = 0, nBad = 0, cyc = 0;

  function automatic int cy(input int ns);
    return (ns * 1000 + PER_PS - 1) / PER_PS;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model
  logic [15:0] mem [16];
  logic [1:0]  rowLat = '0, colLat = '0;
  logic [15:0] lastW = '0;
  bit          wPend = 0;
  logic        mdlOn;
  assign mdlOn = !casN && !oeN && weN;
  assign dq = mdlOn ? mem[{rowLat, colLat}] : 16'bz;

  // pin monitor
  int n = 0;
  logic [10:0] aHist [128];
  logic [15:0] dHist [128];
  int rasFall, rasRise, casFall, casRise, weFall, weRise, oeFall, oeRise, rspAt;
  logic [15:0] rspVal;
  int fallCnt;
  int fallLog [8];
  logic pRas = 1, pCas = 1, pWe = 1, pOe = 1;

  task automatic clearEvents();
    rasFall = -1; rasRise = -1; casFall = -1; casRise = -1;
    weFall = -1; weRise = -1; oeFall = -1; oeRise = -1; rspAt = -1;
    rspVal = '0; fallCnt = 0;
  endtask

  always @(negedge clk) begin
    n++;
    cyc++;
    aHist[n % 128] = dAddr;
    dHist[n % 128] = dq;
    if (!rasN && pRas) begin
      rowLat = dAddr[1:0];
      if (rasFall < 0) rasFall = n;
      if (fallCnt < 8) fallLog[fallCnt] = n;
      fallCnt++;
    end
    if (rasN && !pRas && rasFall >= 0 && rasRise < 0) rasRise = n;
    if (!casN && pCas) begin
      colLat = dAddr[1:0];
      if (casFall < 0) casFall = n;
    end
    if (casN && !pCas && casFall >= 0 && casRise < 0) casRise = n;
    if (!weN && pWe && weFall < 0) weFall = n;
    if (weN && !pWe && weFall >= 0 && weRise < 0) weRise = n;
    if (!oeN && pOe && oeFall < 0) oeFall = n;
    if (oeN && !pOe && oeFall >= 0 && oeRise < 0) oeRise = n;
    if (rspValid && rspAt < 0) begin rspAt = n; rspVal = rspData; end
    if (!weN) begin lastW = dq; wPend = 1; end
    else if (wPend) begin mem[{rowLat, colLat}] = lastW; wPend = 0; end
    pRas = rasN; pCas = casN; pWe = weN; pOe = oeN;
  end

  task automatic waitIdle();
    int g = 0;
    while (!reqReady && g < 400) begin @(negedge clk); g++; end
  endtask

  task automatic runAccess(input vec_t v);
    int g = 0;
    waitIdle();
    clearEvents();
    reqKind = v.kind; reqAddr = {v.row, v.col}; reqWdata = v.wd; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (rspAt < 0 && g < 200) begin @(negedge clk); g++; end
    waitIdle();
  endtask

  task automatic evalAccess(input vec_t v);
    logic [10:0] colPin;
    colPin = {1'b0, v.col};
    // R3 address multiplexing
    check(aHist[(rasFall - 1) % 128] == v.row && aHist[rasFall % 128] == v.row,
          "R3 row around row fall", int'(aHist[rasFall % 128]), int'(v.row));
    check(aHist[(casFall - 2) % 128] == v.row && aHist[(casFall - 1) % 128] == colPin,
          "R3 column one cycle before column fall", int'(aHist[(casFall - 1) % 128]), int'(colPin));
    check(aHist[(rasRise - 1) % 128] == colPin && aHist[(casRise - 1) % 128] == colPin,
          "R3 column held to strobe rise", int'(aHist[(rasRise - 1) % 128]), int'(colPin));
    check(rasRise - (casFall - 1) >= cy(25) && casRise - (casFall - 1) >= cy(13),
          "R3 column before strobe rise", rasRise - casFall + 1, cy(25));
    if (v.kind == 2'd2) begin
      check(rasRise - rasFall >= cy(75), "R6 row low", rasRise - rasFall, cy(75));
      check(casRise - casFall >= cy(38), "R6 column low", casRise - casFall, cy(38));
      check(casRise - rasFall >= cy(70) && rasRise - casFall >= cy(38),
            "R6 strobe holds", casRise - rasFall, cy(70));
      check(weFall - casFall >= cy(28), "R7 we after column fall", weFall - casFall, cy(28));
      check(weFall - rasFall >= cy(65), "R7 we after row fall", weFall - rasFall, cy(65));
      check(weFall - (casFall - 1) >= cy(40), "R7 we after column address", weFall - casFall + 1, cy(40));
      check(oeFall == casFall && oeRise - weFall >= cy(13), "R7 oe hold", oeRise - weFall, cy(13));
      check(dHist[(weRise - 1) % 128] === v.wd, "R7 write word on bus",
            int'(dHist[(weRise - 1) % 128]), int'(v.wd));
      check(rspVal === v.exp, "R9 old word returned", int'(rspVal), int'(v.exp));
      check(mem[{v.row[1:0], v.col[1:0]}] === v.wd, "R9 new word stored",
            int'(mem[{v.row[1:0], v.col[1:0]}]), int'(v.wd));
    end else begin
      check(rasRise - rasFall >= cy(50) && casRise - casFall >= cy(8),
            "R2 strobe widths", rasRise - rasFall, cy(50));
      check(casRise - rasFall >= cy(35) && rasRise - casFall >= cy(13),
            "R2 strobe holds", casRise - rasFall, cy(35));
    end
    if (v.kind == 2'd1) begin
      check(weFall >= 0 && weFall <= casFall, "R5 we before column fall", weFall, casFall);
      check(weRise - casFall >= cy(8), "R5 we hold", weRise - casFall, cy(8));
      check(oeFall < 0, "R5 oe stays high", oeFall, -1);
      for (int i = weFall; i < weRise; i++)
        check(dHist[i % 128] === v.wd, "R5 write word driven", int'(dHist[i % 128]), int'(v.wd));
    end
    if (v.kind == 2'd1 || v.kind == 2'd2) begin
      check(weRise - weFall >= cy(8), "R8 write pulse", weRise - weFall, cy(8));
      check(casRise - weFall >= cy(8) && rasRise - weFall >= cy(8),
            "R8 strobes after we", casRise - weFall, cy(8));
    end
    if (v.kind == 2'd0 || v.kind == 2'd3) begin
      check(weFall < 0, "R4 R11 we stays high", weFall, -1);
      check(oeFall == casFall && oeRise == casRise, "R4 oe with column strobe", oeFall, casFall);
      check(rspAt == rasRise, "R4 response with row rise", rspAt, rasRise);
      check(rspVal === v.exp, v.kind == 2'd3 ? "R11 read data" : "R4 read data",
            int'(rspVal), int'(v.exp));
    end
  endtask

  initial begin
    vec_t v;
    for (int i = 0; i < 16; i++) mem[i] = 16'hA000 + 16'(i);
    clearEvents();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rasN && casN && weN && oeN, "R1 strobes high in reset",
          int'({rasN, casN, weN, oeN}), 15);
    check(dq === 16'bz && !rspValid, "R1 bus released, no response", int'(rspValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady === 1'b1, "R1 ready after reset", int'(reqReady), 1);

    for (int k = 0; k < NV; k++) begin
      runAccess(VEC[k]);
      evalAccess(VEC[k]);
    end

    // R12 rounding at the default clock
    runAccess(VEC[0]);
    check(rasRise - rasFall == cy(50), "R12 read row low cycles", rasRise - rasFall, cy(50));
    check(casRise - rasFall == cy(35), "R12 column rise step", casRise - rasFall, cy(35));

    // R10 back-to-back reads with request held
    for (int kk = 0; kk < 2; kk++) begin
      int g = 0;
      int minC;
      waitIdle();
      clearEvents();
      reqKind = (kk == 0) ? 2'd0 : 2'd2;
      reqAddr = {11'h001, 10'h001};
      reqWdata = 16'h4444;
      minC = (kk == 0) ? cy(84) : cy(109);
      reqValid = 1'b1;
      while (fallCnt < 2 && g < 300) begin @(negedge clk); g++; end
      reqValid = 1'b0;
      check(fallCnt >= 2 && fallLog[1] - fallLog[0] >= minC, "R10 cycle minimum",
            fallLog[1] - fallLog[0], minC);
      check(fallLog[1] - fallLog[0] <= minC + 1, "R10 restart when held",
            fallLog[1] - fallLog[0], minC + 1);
      waitIdle();
    end

    // R10 requests while busy are ignored
    waitIdle();
    clearEvents();
    v = VEC[9];
    reqKind = 2'd0; reqAddr = {v.row, v.col}; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (4) @(negedge clk);
    check(reqReady === 1'b0, "R10 not ready while busy", int'(reqReady), 0);
    reqKind = 2'd1; reqWdata = 16'hFFFF; reqValid = 1'b1;
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    waitIdle();
    repeat (2) @(negedge clk);
    check(fallCnt == 1, "R10 busy request started nothing", fallCnt, 1);
    runAccess(VEC[9]);
    check(rspVal === 16'h0F0F, "R10 memory untouched by busy request", int'(rspVal), 16'h0F0F);

    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    nChk++;
    nBad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

endmodule